// File: doc/BRIEF.md
# Paired-Core Slot Donation Arbiter

This block arbitrates access to a shared memory among sixteen cores. A free-running slot counter visits each core in turn, and the core whose index matches the counter owns that clock. By default, a core that owns a slot uses it if it is requesting, and the slot is otherwise lost.

Cores are grouped in fixed neighbour pairs: cores 2k and 2k+1 form pair k. Each pair can be given one of several sharing policies. Under these policies a slot that one member does not use can go to the other member, either member can be given first claim, or the even member can take both slots of the pair. Sharing never reaches outside a pair, so a core whose pair is not shared sees the same slot timing whatever the other pairs do.

The policy inputs may change at any time. The arbiter samples them only as the counter rolls over to slot 0, so a policy always covers whole rotations. The grant is combinational from the request lines in the cycle of the slot.

Top module: `paired_slot_arbiter`

## Requirements
- R1: While reset is held, the slot counter is at 0. After reset, it advances by one on every clock and returns from 15 to 0. In slot s, only core s or its pair mate can be granted.
- R2: At most one grant bit is high in any cycle, and a grant bit is high only for a core whose request bit is high in that cycle.
- R3: With pair policy 00 (unshared), core s is granted in slot s exactly when it requests. Its mate is never granted in that slot.
- R4: With pair policy 01 (slot owner first), the slot owner is granted when it requests. If it does not request, the mate is granted when the mate requests.
- R5: With pair policy 10 (mate first), the mate is granted in the owner's slot when the mate requests. If the mate does not request, the owner is granted when it requests.
- R6: With pair policy 11 (even core takes both), the even core of the pair is granted in both pair slots when it requests. The odd core is never granted.
- R7: The policy inputs are sampled at the clock edge that moves the counter from 15 to 0. A change made mid-rotation has no effect until slot 0. Reset sets every pair to policy 00.
- R8: The policy of one pair never changes which core is granted in a slot belonging to another pair. For pair k, the policy is carried on pair_mode_i bits [2k+1:2k].
- R9: When no core that the current policy allows in a slot is requesting, no grant is asserted in that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Per-core access request, bit c for core c |
| pair_mode_i | input | 16 | Per-pair policy, two bits per pair, pair k at [2k+1:2k] |
| grant_o | output | 16 | Per-core grant for the current slot, at most one bit high |

## Verification
The assertions assume that the request lines are stable around the clock edge. They also assume that pair_mode_i is settled at the 15-to-0 edge, since the mode bank checks that it copies the value present at that edge. The bench drives requests and policies only on falling edges, and it reads grants a nanosecond later. It tracks the slot with its own counter started from the reset release, and it places policy changes both before a rollover and in the middle of a rotation.

// File: rtl/psa_pkg.sv
package psa_pkg;

    typedef enum logic [1:0] {
        PM_SOLO    = 2'b00,
        PM_OWNER   = 2'b01,
        PM_MATE    = 2'b10,
        PM_EVEN    = 2'b11
    } pair_mode_e;

endpackage

// File: rtl/psa_slot_ring.sv
module psa_slot_ring #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic              wrap_o
);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d      = ring_q;
        ring_d.slot = ring_q.slot + SLOT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    assign slot_o = ring_q.slot;
    assign wrap_o = (ring_q.slot == SLOT_W'(NUM_SLOTS - 1));

    assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (slot_o == SLOT_W'($past(slot_o) + SLOT_W'(1))));

    assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (slot_o == '0));

endmodule

// File: rtl/psa_mode_bank.sv
module psa_mode_bank #(
    parameter int NUM_PAIRS = 8,
    localparam int MODE_W   = 2 * NUM_PAIRS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [MODE_W-1:0] active_o
);

    typedef struct packed {
        logic [MODE_W-1:0] active;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wrap_i) bank_d.active = mode_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign active_o = bank_q.active;

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(active_o));

    assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (active_o == $past(mode_i)));

endmodule

// File: rtl/psa_grant_decode.sv
module psa_grant_decode
    import psa_pkg::*;
#(
    parameter int NUM_CORES = 16,
    localparam int SLOT_W   = $clog2(NUM_CORES),
    localparam int MODE_W   = NUM_CORES
) (
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic [NUM_CORES-1:0] req_i,
    input  logic [MODE_W-1:0]    active_i,
    output logic [NUM_CORES-1:0] grant_o
);

    logic [SLOT_W-1:0] owner;
    logic [SLOT_W-1:0] mate;
    logic [SLOT_W-1:0] even_core;
    pair_mode_e        mode;

    always_comb begin
        owner     = slot_i;
        mate      = slot_i ^ SLOT_W'(1);
        even_core = {slot_i[SLOT_W-1:1], 1'b0};
        mode      = pair_mode_e'(active_i[{slot_i[SLOT_W-1:1], 1'b0} +: 2]);
        grant_o   = '0;
        case (mode)
            PM_SOLO: begin
                if (req_i[owner]) grant_o[owner] = 1'b1;
            end
            PM_OWNER: begin
                if (req_i[owner])     grant_o[owner] = 1'b1;
                else if (req_i[mate]) grant_o[mate]  = 1'b1;
            end
            PM_MATE: begin
                if (req_i[mate])       grant_o[mate]  = 1'b1;
                else if (req_i[owner]) grant_o[owner] = 1'b1;
            end
            default: begin
                if (req_i[even_core]) grant_o[even_core] = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/paired_slot_arbiter.sv
module paired_slot_arbiter
    import psa_pkg::*;
#(
    parameter int NUM_CORES = 16,
    localparam int SLOT_W   = $clog2(NUM_CORES),
    localparam int NUM_PAIRS = NUM_CORES / 2,
    localparam int MODE_W   = 2 * NUM_PAIRS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] req_i,
    input  logic [MODE_W-1:0]    pair_mode_i,
    output logic [NUM_CORES-1:0] grant_o
);

    logic [SLOT_W-1:0] slot;
    logic              wrap;
    logic [MODE_W-1:0] active;

    psa_slot_ring #(.NUM_SLOTS(NUM_CORES)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot),
        .wrap_o (wrap)
    );

    psa_mode_bank #(.NUM_PAIRS(NUM_PAIRS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_i   (wrap),
        .mode_i   (pair_mode_i),
        .active_o (active)
    );

    psa_grant_decode #(.NUM_CORES(NUM_CORES)) u_decode (
        .slot_i   (slot),
        .req_i    (req_i),
        .active_i (active),
        .grant_o  (grant_o)
    );

    logic [NUM_CORES-1:0] pair_mask;
    assign pair_mask = NUM_CORES'(2'b11) << {slot[SLOT_W-1:1], 1'b0};

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    assert_grant_in_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~pair_mask) == '0);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
        assert_odd_starved_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (active[2*p +: 2] == 2'b11) |-> !grant_o[2*p + 1]);

        assert_solo_no_mate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ((active[2*p +: 2] == 2'b00) && (slot[SLOT_W-1:1] == (SLOT_W-1)'(p)))
                |-> !grant_o[{slot[SLOT_W-1:1], ~slot[0]}]);
    end

endmodule

// File: tb/paired_slot_arbiter_tb.sv
`timescale 1ns/1ps
module paired_slot_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [15:0] pair_mode = '0;
    logic [15:0] grant;

    int n_checks = 0;
    int n_err = 0;
    int tb_slot = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    paired_slot_arbiter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .pair_mode_i (pair_mode),
        .grant_o     (grant)
    );

    always @(posedge clk) begin
        if (!rst_n) tb_slot <= 0;
        else        tb_slot <= (tb_slot + 1) % 16;
    end

    task automatic check(string tag, logic [15:0] exp);
        n_checks++;
        if (grant !== exp) begin
            n_err++;
            $display("FAIL %s slot=%0d: grant=%h expected=%h", tag, tb_slot, grant, exp);
        end
    endtask

    task automatic goto_slot(int s);
        while (tb_slot != s) @(negedge clk);
    endtask

    task automatic drive_check(int s, logic [15:0] r, logic [15:0] exp, string tag);
        goto_slot(s);
        req = r;
        #1;
        check(tag, exp);
    endtask

    task automatic apply_modes(logic [15:0] m);
        pair_mode = m;
        goto_slot(15);
        @(negedge clk);
    endtask

    task automatic t_reset;
        req = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R1 reset slot 0", 16'h0001);
        check("R7 reset policy unshared", 16'h0001);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 first slot after reset", 16'h0002);
    endtask

    task automatic t_rotation;
        apply_modes(16'h0000);
        for (int s = 0; s < 16; s++) drive_check(s, 16'hFFFF, 16'(1) << s, "R1 R3 rotation");
        drive_check(0, 16'hFFFF, 16'h0001, "R1 wrap to 0");
        drive_check(4, 16'h0020, 16'h0000, "R3 R9 mate never in solo");
        drive_check(5, 16'h0020, 16'h0020, "R3 owner granted");
    endtask

    task automatic t_owner_first;
        apply_modes(16'h0004);
        drive_check(2, 16'h000C, 16'h0004, "R4 owner wins");
        drive_check(2, 16'h0008, 16'h0008, "R4 mate takes idle");
        drive_check(3, 16'h0004, 16'h0004, "R4 even takes odd idle slot");
        drive_check(3, 16'h0000, 16'h0000, "R9 no requester");
    endtask

    task automatic t_mate_first;
        apply_modes(16'h0008);
        drive_check(2, 16'h000C, 16'h0008, "R5 mate wins");
        drive_check(2, 16'h0004, 16'h0004, "R5 owner when mate idle");
        drive_check(3, 16'h000C, 16'h0004, "R5 mate wins odd slot");
    endtask

    task automatic t_even_takes;
        apply_modes(16'h3000);
        drive_check(12, 16'h3000, 16'h1000, "R6 even slot");
        drive_check(13, 16'h3000, 16'h1000, "R6 odd slot to even");
        drive_check(13, 16'h2000, 16'h0000, "R6 R9 odd never");
    endtask

    task automatic t_all_pairs;
        apply_modes(16'hFFFF);
        for (int s = 0; s < 16; s++)
            drive_check(s, 16'hFFFF, 16'(1) << (s & ~1), "R6 eight pairs");
    endtask

    task automatic t_isolation;
        apply_modes(16'hFFCF);
        drive_check(4, 16'h0030, 16'h0010, "R8 unshared pair kept");
        drive_check(5, 16'h0030, 16'h0020, "R8 unshared pair own slot");
        drive_check(9, 16'h0200, 16'h0000, "R8 neighbour policy local");
    endtask

    task automatic t_latency;
        apply_modes(16'h0000);
        goto_slot(5);
        pair_mode = 16'hC000;
        drive_check(15, 16'h8000, 16'h8000, "R7 old policy until wrap");
        @(negedge clk);
        drive_check(14, 16'hC000, 16'h4000, "R7 new policy after wrap");
        drive_check(15, 16'h8000, 16'h0000, "R7 odd starved after wrap");
    endtask

    initial begin
        t_reset();
        t_rotation();
        t_owner_first();
        t_mate_first();
        t_even_takes();
        t_all_pairs();
        t_isolation();
        t_latency();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule